// File: doc/BRIEF.md
# Frequency Correction and Error Register Pair

This block sits between a receiver's frequency-tracking loop and a byte-wide register port. It stores a 16-bit two's-complement frequency-correction value and a 16-bit two's-complement measured frequency error. Software can read both values one byte at a time and can overwrite the correction value. The tracking loop can also load a new correction value. A control register holds an auto-clear enable, a write-to-clear bit and a write-to-trigger bit that starts a gain-control sequence. The estimation algorithms are outside this block.

The error value arrives from the estimator together with a valid strobe. Software must read its high byte first. That read freezes the matching low byte in a shadow register, so the two bytes always belong to the same measurement. The correction value is driven out continuously to the loop. When the automatic correction phase starts, the value is cleared if software has asked for that.

Register map, one byte each, addressed by `reg_addr`:
- 0: control.
- 1: correction value, high byte.
- 2: correction value, low byte.
- 3: error, high byte.
- 4: error, low byte.
- 5 to 7: unused.

Control bits:
- Bit 0 is the auto-clear enable. It can be read and written.
- Bit 1 is the clear bit.
- Bit 2 is the gain-control trigger bit.

Top module: `afc_fei_regs`

## Requirements
- R1: After reset, `afc_value` is 0, `agc_start` is 0, and every register address reads 0.
- R2: A write to address 1 replaces bits 15:8 of the correction value, and a write to address 2 replaces bits 7:0. The new value is on `afc_value` one clock after the write, and it reads back at the same addresses.
- R3: When `loop_upd_valid` is high in a cycle with no software write to the correction value and no auto-clear, `afc_value` takes `loop_upd_value` on the next clock.
- R4: If a software byte write to the correction value and a loop update fall in the same cycle, the software write wins. The written byte is stored, the other byte is kept, and the loop update is dropped.
- R5: Writing 1 to control bit 1 while `rx_active` is high zeroes `afc_value` on the next clock. While `rx_active` is low the same write has no effect on the value. Bit 1 always reads 0.
- R6: Writing 1 to control bit 2 makes `agc_start` high for exactly one clock cycle, in the cycle after the write. Bit 2 always reads 0.
- R7: A `afc_phase_start` pulse zeroes `afc_value` on the next clock only when control bit 0 is 1 and `auto_afc_on` is high. In that case it also takes priority over a loop update in the same cycle. In every other case the value is kept.
- R8: A `fei_valid` strobe captures `fei_value`. Its high byte then reads at address 3.
- R9: A read of address 3 copies the current error low byte into a shadow register. A read of address 4 returns that shadow, even if a newer measurement has arrived since the high-byte read.
- R10: Addresses 5 to 7 read 0 and ignore writes. Control bits 7:3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Byte write strobe |
| reg_rd | input | 1 | Byte read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle `reg_rd` is high, 0 otherwise |
| fei_valid | input | 1 | New error measurement strobe |
| fei_value | input | 16 | Measured frequency error, two's complement |
| loop_upd_valid | input | 1 | Correction update strobe from the loop |
| loop_upd_value | input | 16 | Correction value from the loop |
| afc_phase_start | input | 1 | Pulse at the start of an automatic correction phase |
| auto_afc_on | input | 1 | Automatic correction enabled |
| rx_active | input | 1 | Receiver is in receive mode |
| afc_value | output | 16 | Current correction value |
| agc_start | output | 1 | One-cycle gain-control start pulse |

## Verification
A wrong correction state shows on `afc_value` at the very next negative clock edge after the write, clear, auto-clear or loop update that caused it. Corruption by a dropped priority therefore appears within one cycle. A shadow register that was not latched, or was overwritten, only shows when software reads address 4 after a newer measurement has arrived. The bench therefore changes the measurement between the two byte reads. A stuck or stretched trigger shows as a wrong pulse count on `agc_start` within two cycles of the control write.

// File: rtl/afc_fei_pkg.sv
package afc_fei_pkg;
    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_CORR_HI = 1;
    localparam int ADDR_CORR_LO = 2;
    localparam int ADDR_ERR_HI  = 3;
    localparam int ADDR_ERR_LO  = 4;

    localparam int BIT_AUTO_CLR = 0;
    localparam int BIT_CLEAR    = 1;
    localparam int BIT_AGC      = 2;
    localparam int CTRL_BITS    = 3;
endpackage

// File: rtl/afc_ctrl.sv
module afc_ctrl
    import afc_fei_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic [CTRL_BITS-1:0] wbits,
    output logic                 auto_clr_en,
    output logic                 agc_start
);
    typedef struct packed {
        logic auto_en;
        logic agc;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.agc = wr_ctrl && wbits[BIT_AGC];
        if (wr_ctrl) st_d.auto_en = wbits[BIT_AUTO_CLR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign auto_clr_en = st_q.auto_en;
    assign agc_start   = st_q.agc;

    // R6: a pulse is only ever the echo of a trigger write one cycle back
    p_agc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        agc_start |-> $past(wr_ctrl && wbits[BIT_AGC]));
    p_agc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (agc_start && !wr_ctrl) |=> !agc_start);
endmodule

// File: rtl/afc_corr.sv
module afc_corr #(
    parameter int VAL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic [VAL_W/2-1:0] wdata,
    input  logic               clr_req,
    input  logic               auto_clr,
    input  logic               upd_valid,
    input  logic [VAL_W-1:0]   upd_value,
    output logic [VAL_W-1:0]   value
);
    localparam int BYTE_W = VAL_W / 2;

    typedef struct packed {
        logic [VAL_W-1:0] val;
    } corr_t;

    corr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_req) begin
            st_d.val = '0;
        end else if (wr_hi || wr_lo) begin
            if (wr_hi) st_d.val[VAL_W-1:BYTE_W] = wdata;
            if (wr_lo) st_d.val[BYTE_W-1:0]     = wdata;
        end else if (auto_clr) begin
            st_d.val = '0;
        end else if (upd_valid) begin
            st_d.val = upd_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.val;

    p_loop_upd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !wr_hi && !wr_lo && !clr_req && !auto_clr) |=> (value == $past(upd_value)));
    p_sw_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && upd_valid && !clr_req) |=>
            (value[VAL_W-1:BYTE_W] == $past(wdata)) && (value[BYTE_W-1:0] == $past(value[BYTE_W-1:0])));
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (value == '0));
    p_auto_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr && !wr_hi && !wr_lo) |=> (value == '0));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi && !wr_lo && !clr_req && !auto_clr && !upd_valid) |=> $stable(value));
endmodule

// File: rtl/fei_snap.sv
module fei_snap #(
    parameter int VAL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               meas_valid,
    input  logic [VAL_W-1:0]   meas_value,
    input  logic               rd_hi,
    output logic [VAL_W-1:0]   err,
    output logic [VAL_W/2-1:0] shadow_lo
);
    localparam int BYTE_W = VAL_W / 2;

    typedef struct packed {
        logic [VAL_W-1:0]  err;
        logic [BYTE_W-1:0] shadow;
    } snap_t;

    snap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_hi)      st_d.shadow = st_q.err[BYTE_W-1:0];
        if (meas_valid) st_d.err    = meas_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err       = st_q.err;
    assign shadow_lo = st_q.shadow;

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> (err == $past(meas_value)));
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hi |=> $stable(shadow_lo));
    p_shadow_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> (shadow_lo == $past(err[BYTE_W-1:0])));
endmodule

// File: rtl/afc_fei_regs.sv
module afc_fei_regs
    import afc_fei_pkg::*;
#(
    parameter int VAL_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [VAL_W/2-1:0] reg_wdata,
    output logic [VAL_W/2-1:0] reg_rdata,
    input  logic               fei_valid,
    input  logic [VAL_W-1:0]   fei_value,
    input  logic               loop_upd_valid,
    input  logic [VAL_W-1:0]   loop_upd_value,
    input  logic               afc_phase_start,
    input  logic               auto_afc_on,
    input  logic               rx_active,
    output logic [VAL_W-1:0]   afc_value,
    output logic               agc_start
);
    localparam int BYTE_W = VAL_W / 2;

    logic              sel_ctrl, sel_chi, sel_clo, sel_ehi, sel_elo;
    logic              wr_ctrl, auto_en, clr_req, auto_clr;
    logic [VAL_W-1:0]  err_w;
    logic [BYTE_W-1:0] shadow_w;
    logic [BYTE_W-1:0] rdata_d;

    assign sel_ctrl = (reg_addr == ADDR_W'(ADDR_CTRL));
    assign sel_chi  = (reg_addr == ADDR_W'(ADDR_CORR_HI));
    assign sel_clo  = (reg_addr == ADDR_W'(ADDR_CORR_LO));
    assign sel_ehi  = (reg_addr == ADDR_W'(ADDR_ERR_HI));
    assign sel_elo  = (reg_addr == ADDR_W'(ADDR_ERR_LO));

    assign wr_ctrl  = reg_wr && sel_ctrl;
    assign clr_req  = wr_ctrl && reg_wdata[BIT_CLEAR] && rx_active;
    assign auto_clr = afc_phase_start && auto_en && auto_afc_on;

    afc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wbits       (reg_wdata[CTRL_BITS-1:0]),
        .auto_clr_en (auto_en),
        .agc_start   (agc_start)
    );

    afc_corr #(.VAL_W(VAL_W)) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hi     (reg_wr && sel_chi),
        .wr_lo     (reg_wr && sel_clo),
        .wdata     (reg_wdata),
        .clr_req   (clr_req),
        .auto_clr  (auto_clr),
        .upd_valid (loop_upd_valid),
        .upd_value (loop_upd_value),
        .value     (afc_value)
    );

    fei_snap #(.VAL_W(VAL_W)) u_fei (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (fei_valid),
        .meas_value (fei_value),
        .rd_hi      (reg_rd && sel_ehi),
        .err        (err_w),
        .shadow_lo  (shadow_w)
    );

    always_comb begin
        rdata_d = '0;
        if (reg_rd) begin
            if (sel_ctrl)     rdata_d[BIT_AUTO_CLR] = auto_en;
            else if (sel_chi) rdata_d = afc_value[VAL_W-1:BYTE_W];
            else if (sel_clo) rdata_d = afc_value[BYTE_W-1:0];
            else if (sel_ehi) rdata_d = err_w[VAL_W-1:BYTE_W];
            else if (sel_elo) rdata_d = shadow_w;
        end
    end

    assign reg_rdata = rdata_d;

    p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr > ADDR_W'(ADDR_ERR_LO)) |-> (reg_rdata == '0));
    p_ctrl_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel_ctrl) |-> (reg_rdata[BYTE_W-1:1] == '0));
    p_idle_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));
endmodule

// File: tb/tb_afc_fei_regs.sv
module tb_afc_fei_regs;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        fei_valid = 0;
    logic [15:0] fei_value = '0;
    logic        loop_upd_valid = 0;
    logic [15:0] loop_upd_value = '0;
    logic        afc_phase_start = 0, auto_afc_on = 0, rx_active = 0;
    logic [15:0] afc_value;
    logic        agc_start;

    int checks = 0, failures = 0, pulses = 0;

    always #4 clk = ~clk;

    afc_fei_regs dut (.*);

    always @(negedge clk) if (agc_start) pulses++;

    // {write, addr[2:0], data[7:0], expected[7:0]}
    localparam int NV = 12;
    localparam logic [19:0] VEC [0:NV-1] = '{
        {1'b1, 3'd1, 8'h12, 8'h00},  // R2 high byte
        {1'b1, 3'd2, 8'h34, 8'h00},  // R2 low byte
        {1'b0, 3'd1, 8'h00, 8'h12},  // R2
        {1'b0, 3'd2, 8'h00, 8'h34},  // R2
        {1'b1, 3'd0, 8'hFB, 8'h00},  // R5 clear outside receive, R10 upper bits
        {1'b0, 3'd0, 8'h00, 8'h01},  // R5 clear reads 0, R10 bits 7:3 read 0
        {1'b0, 3'd1, 8'h00, 8'h12},  // R5 value kept when rx_active low
        {1'b1, 3'd5, 8'hAA, 8'h00},  // R10
        {1'b0, 3'd5, 8'h00, 8'h00},  // R10
        {1'b0, 3'd7, 8'h00, 8'h00},  // R10
        {1'b1, 3'd0, 8'h00, 8'h00},
        {1'b0, 3'd0, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #2;
        chk(req, {8'h00, reg_rdata}, {8'h00, exp});
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic upd(input logic [15:0] v);
        @(negedge clk);
        loop_upd_valid = 1; loop_upd_value = v;
        @(negedge clk);
        loop_upd_valid = 0;
    endtask

    task automatic phase();
        @(negedge clk);
        afc_phase_start = 1;
        @(negedge clk);
        afc_phase_start = 0;
    endtask

    initial begin
        #(8 * 20000);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk("R1 afc_value", afc_value, 16'h0000);
        chk("R1 agc_start", {15'd0, agc_start}, 16'h0000);
        for (int a = 0; a < 5; a++) rd("R1 readback", 3'(a), 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
            else            rd("R2/R5/R10 vector", VEC[i][18:16], VEC[i][7:0]);
        end
        chk("R2 afc_value", afc_value, 16'h1234);

        // R3 loop update
        upd(16'h0F0F);
        chk("R3 loop update", afc_value, 16'h0F0F);

        // R4 software write beats loop update
        @(negedge clk);
        reg_wr = 1; reg_addr = 3'd1; reg_wdata = 8'h55;
        loop_upd_valid = 1; loop_upd_value = 16'hAAAA;
        @(negedge clk);
        reg_wr = 0; loop_upd_valid = 0;
        chk("R4 priority", afc_value, 16'h550F);

        // R5 clear in receive mode
        rx_active = 1;
        wr(3'd0, 8'h02);
        chk("R5 clear in rx", afc_value, 16'h0000);
        rd("R5 clear bit reads 0", 3'd0, 8'h00);
        rx_active = 0;

        // R6 single gain-control pulse
        repeat (2) @(negedge clk);
        pulses = 0;
        wr(3'd0, 8'h04);
        repeat (3) @(negedge clk);
        chk("R6 pulse count", 16'(pulses), 16'd1);
        rd("R6 trigger bit reads 0", 3'd0, 8'h00);

        // R7 auto-clear conditions
        wr(3'd0, 8'h01);
        upd(16'h1111);
        auto_afc_on = 0;
        phase();
        chk("R7 kept when auto off", afc_value, 16'h1111);
        auto_afc_on = 1;
        phase();
        chk("R7 cleared", afc_value, 16'h0000);
        @(negedge clk);
        afc_phase_start = 1; loop_upd_valid = 1; loop_upd_value = 16'h7777;
        @(negedge clk);
        afc_phase_start = 0; loop_upd_valid = 0;
        chk("R7 auto-clear beats update", afc_value, 16'h0000);
        upd(16'h2222);
        wr(3'd0, 8'h00);
        phase();
        chk("R7 kept when enable off", afc_value, 16'h2222);
        auto_afc_on = 0;

        // R8 / R9 error capture and coherent snapshot
        @(negedge clk);
        fei_valid = 1; fei_value = 16'hBEEF;
        @(negedge clk);
        fei_valid = 0;
        rd("R8 error high", 3'd3, 8'hBE);
        @(negedge clk);
        fei_valid = 1; fei_value = 16'h1234;
        @(negedge clk);
        fei_valid = 0;
        rd("R9 shadow low", 3'd4, 8'hEF);
        rd("R8 new high", 3'd3, 8'h12);
        rd("R9 new low", 3'd4, 8'h34);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule